// File: doc/BRIEF.md
# Shadowed Clock Register File

This block is the register face of a real-time clock: the eight topmost byte locations of a byte-wide memory interface with chip-enable, output-enable and write-enable. It keeps a user copy of the calendar bytes that is separate from the live calendar counter outside the block. While no halt is requested, each one-second tick copies the live counter fields into the user copy. The copy is deferred while the host is touching the clock area, so a value is never seen half updated.

Control and status bits occupy the spare bits of the time bytes. The byte at the lowest clock address holds two halt bits. The read halt freezes the user copy so the host can read a consistent snapshot. The write halt freezes it so the host can edit it; when the write halt is cleared, the edited fields are handed to the live counter with a one-cycle load strobe. The seconds byte carries an oscillator stop bit. The day byte carries a frequency test enable and a battery-good flag that cannot be written. Every bit with no assigned function is plain storage.

The bus is sampled on the system clock. Read data and its drive enable are registered, so they appear one cycle after the access is sampled.

Top module: `rtc_shadow_regs`

## Requirements
- R1: An address whose bits above bit 2 are all ones selects the clock area. Bits 2:0 choose the byte: 0 control/century, 1 seconds, 2 minutes, 3 hours, 4 day, 5 date, 6 month, 7 year. Any other address neither drives data nor changes a clock byte.
- R2: A read is ce_n=0, oe_n=0, we_n=1. A write is ce_n=0, we_n=0, and it wins over oe_n. After a read of the clock area is sampled, data_oe is 1 and data_out holds the byte in the next cycle. In every other case data_oe is 0, including a write made with oe_n low.
- R3: A write stores all eight bits of the addressed byte, except the day battery bit. Unassigned bits read back exactly as written.
- R4: Day bit 7 always reads as the batt_ok input. Writes to it are ignored.
- R5: While neither halt bit is set, a tick_sec pulse copies the counter fields of live_time (byte i at bits 8i+7:8i) into the user copy. The fields are century 5:0, seconds 6:0, minutes 6:0, hours 5:0, day 2:0, date 5:0, month 4:0 and year 7:0. All other bits keep their stored value.
- R6: A copy that falls due during a clock-area access waits and is made in the first cycle with no such access.
- R7: While control bit 6 (read halt) is 1, the user copy does not follow ticks. Clearing the bit makes a pending copy happen at the first idle cycle.
- R8: While control bit 7 (write halt) is 1, ticks are ignored and writes edit the user copy. A write that clears the bit raises load_stb for exactly one cycle, in the cycle after the write. load_time then shows the counter fields of the user copy, with all other bits zero. Any pending copy is dropped.
- R9: osc_stop equals seconds bit 7.
- R10: While day bit 6 is 1 and seconds bit 7 is 0, seconds bit 0 reads as a toggle that flips on each tick_fast pulse. The toggle is 0 after reset and holds its value while the test mode is not active.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| addr | input | ADDR_W | Byte address |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| we_n | input | 1 | Write enable, active low |
| data_in | input | 8 | Write data |
| data_out | output | 8 | Registered read data |
| data_oe | output | 1 | Drive enable for data_out |
| tick_sec | input | 1 | One-second pulse from the calendar counter |
| tick_fast | input | 1 | 512 Hz pulse for frequency test |
| batt_ok | input | 1 | Battery good status |
| live_time | input | 64 | Live calendar counter bytes |
| load_time | output | 64 | Counter fields handed to the calendar counter |
| load_stb | output | 1 | One-cycle load request |
| osc_stop | output | 1 | Oscillator stop request |

## Verification
The bench builds the block with a 5-bit address. This puts the whole address space within one sweep: all 24 locations below the clock area are read and written, and none of them may respond. Each of the eight clock bytes is written with all 256 values and read back, which covers every spare bit, the battery bit against batt_ok, and the oscillator stop output. Directed sequences then check the tick copy masks, deferral under a held read, both halt releases with the load strobe, and the frequency test toggle.

// File: rtl/rtc_shadow_pkg.sv
package rtc_shadow_pkg;
  localparam int NREG   = 8;
  localparam int BYTE_W = 8;
  localparam int TIME_W = NREG * BYTE_W;

  localparam logic [2:0] IX_CTRL = 3'd0;
  localparam logic [2:0] IX_SEC  = 3'd1;
  localparam logic [2:0] IX_DAY  = 3'd4;

  localparam int HALT_WR_BIT = 7;
  localparam int HALT_RD_BIT = 6;
  localparam int OSC_BIT     = 7;
  localparam int FT_BIT      = 6;
  localparam int BATT_BIT    = 7;

  // Bits of each byte that follow the live counter
  function automatic logic [7:0] field_mask(input logic [2:0] ix);
    case (ix)
      3'd0:    field_mask = 8'h3F;
      3'd1:    field_mask = 8'h7F;
      3'd2:    field_mask = 8'h7F;
      3'd3:    field_mask = 8'h3F;
      3'd4:    field_mask = 8'h07;
      3'd5:    field_mask = 8'h3F;
      3'd6:    field_mask = 8'h1F;
      default: field_mask = 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/rtc_bus_decode.sv
module rtc_bus_decode #(
  parameter int ADDR_W = 19
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  output logic              in_area,
  output logic [2:0]        idx,
  output logic              rd_en,
  output logic              wr_en
);
  assign in_area = &addr[ADDR_W-1:3];
  assign idx     = addr[2:0];
  // write dominates output enable
  assign wr_en   = !ce_n && !we_n;
  assign rd_en   = !ce_n && !oe_n && we_n;
endmodule

// File: rtl/rtc_freq_test.sv
module rtc_freq_test (
  input  logic clk,
  input  logic rst,
  input  logic run,
  input  logic tick_fast,
  output logic tgl_q
);
  always_ff @(posedge clk) begin
    if (rst)                   tgl_q <= 1'b0;
    else if (run && tick_fast) tgl_q <= !tgl_q;
  end

  assert_toggle_hold_R10: assert property (@(posedge clk) disable iff (rst)
    !(run && tick_fast) |=> $stable(tgl_q));
endmodule

// File: rtl/rtc_user_bank.sv
module rtc_user_bank
  import rtc_shadow_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              acc,
  input  logic [2:0]        idx,
  input  logic [7:0]        wdata,
  input  logic              tick_sec,
  input  logic [TIME_W-1:0] live_time,
  output logic [TIME_W-1:0] user_q,
  output logic              load_stb
);
  logic ctl_wr, ctl_rd, halt, want, do_copy, rel_wr, rel_rd, pend_q;

  assign ctl_wr  = user_q[HALT_WR_BIT];
  assign ctl_rd  = user_q[HALT_RD_BIT];
  assign halt    = ctl_wr || ctl_rd;
  assign want    = pend_q || tick_sec;
  assign do_copy = want && !halt && !acc;
  assign rel_wr  = wr_en && (idx == IX_CTRL) && ctl_wr && !wdata[HALT_WR_BIT];
  assign rel_rd  = wr_en && (idx == IX_CTRL) && ctl_rd && !wdata[HALT_RD_BIT];

  for (genvar g = 0; g < NREG; g++) begin : g_byte
    localparam logic [2:0] GI    = 3'(g);
    localparam logic [7:0] FMASK = field_mask(GI);
    localparam logic [7:0] WMASK = (GI == IX_DAY) ? ~(8'h01 << BATT_BIT) : 8'hFF;
    logic [7:0] byte_q;
    always_ff @(posedge clk) begin
      if (rst)
        byte_q <= '0;
      else if (wr_en && idx == GI)
        byte_q <= wdata & WMASK;
      else if (do_copy)
        byte_q <= (byte_q & ~FMASK) | (live_time[BYTE_W*g +: BYTE_W] & FMASK);
    end
    assign user_q[BYTE_W*g +: BYTE_W] = byte_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q   <= 1'b0;
      load_stb <= 1'b0;
    end else begin
      load_stb <= rel_wr;
      if (rel_wr || do_copy) pend_q <= 1'b0;
      else if (want || rel_rd) pend_q <= 1'b1;
    end
  end

  assert_defer_on_access_R6: assert property (@(posedge clk) disable iff (rst)
    (acc && !wr_en) |=> user_q == $past(user_q));
  assert_halt_freeze_R7: assert property (@(posedge clk) disable iff (rst)
    (halt && !wr_en) |=> user_q == $past(user_q));
  assert_load_single_R8: assert property (@(posedge clk) disable iff (rst)
    load_stb |-> (!ctl_wr && !$past(load_stb)));
endmodule

// File: rtl/rtc_shadow_regs.sv
module rtc_shadow_regs
  import rtc_shadow_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr,
  input  logic              ce_n,
  input  logic              oe_n,
  input  logic              we_n,
  input  logic [7:0]        data_in,
  output logic [7:0]        data_out,
  output logic              data_oe,
  input  logic              tick_sec,
  input  logic              tick_fast,
  input  logic              batt_ok,
  input  logic [TIME_W-1:0] live_time,
  output logic [TIME_W-1:0] load_time,
  output logic              load_stb,
  output logic              osc_stop
);
  logic              in_area, rd_en, wr_en, ft_run, tgl;
  logic [2:0]        idx;
  logic [TIME_W-1:0] user_q;
  logic [7:0]        rd_val;

  rtc_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
    .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .in_area(in_area), .idx(idx), .rd_en(rd_en), .wr_en(wr_en));

  rtc_user_bank u_bank (
    .clk(clk), .rst(rst), .wr_en(wr_en && in_area),
    .acc(in_area && (rd_en || wr_en)), .idx(idx), .wdata(data_in),
    .tick_sec(tick_sec), .live_time(live_time), .user_q(user_q),
    .load_stb(load_stb));

  assign osc_stop = user_q[BYTE_W*IX_SEC + OSC_BIT];
  assign ft_run   = user_q[BYTE_W*IX_DAY + FT_BIT] && !osc_stop;

  rtc_freq_test u_ft (
    .clk(clk), .rst(rst), .run(ft_run), .tick_fast(tick_fast), .tgl_q(tgl));

  for (genvar g = 0; g < NREG; g++) begin : g_load
    assign load_time[BYTE_W*g +: BYTE_W] =
      user_q[BYTE_W*g +: BYTE_W] & field_mask(3'(g));
  end

  always_comb begin
    rd_val = user_q[BYTE_W*idx +: BYTE_W];
    if (idx == IX_DAY) rd_val[BATT_BIT] = batt_ok;
    if (idx == IX_SEC && ft_run) rd_val[0] = tgl;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      data_oe  <= 1'b0;
      data_out <= '0;
    end else begin
      data_oe  <= rd_en && in_area;
      data_out <= (rd_en && in_area) ? rd_val : '0;
    end
  end

  assert_bus_release_on_write_R2: assert property (@(posedge clk) disable iff (rst)
    (!ce_n && !we_n) |=> !data_oe);
  assert_batt_flag_read_R4: assert property (@(posedge clk) disable iff (rst)
    (rd_en && in_area && idx == IX_DAY) |=> data_out[BATT_BIT] == $past(batt_ok));
endmodule

// File: tb/rtc_shadow_regs_tb.sv
module rtc_shadow_regs_tb;
  localparam int AW = 5;
  logic clk = 0, rst = 1;
  logic [AW-1:0] addr = '0;
  logic ce_n = 1, oe_n = 1, we_n = 1, tick_sec = 0, tick_fast = 0, batt_ok = 1;
  logic [7:0] data_in = '0, data_out;
  logic data_oe, load_stb, osc_stop;
  logic [63:0] live_time, load_time;
  logic [7:0] lv [8];
  logic [7:0] ub [8];
  logic tgl_m = 0;
  int checks = 0, fails = 0;
  bit done = 0;
  logic ld_seen;
  logic [63:0] ld_val;

  always #2 clk = !clk;
  assign live_time = {lv[7], lv[6], lv[5], lv[4], lv[3], lv[2], lv[1], lv[0]};

  rtc_shadow_regs #(.ADDR_W(AW)) u_dut (
    .clk(clk), .rst(rst), .addr(addr), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
    .data_in(data_in), .data_out(data_out), .data_oe(data_oe),
    .tick_sec(tick_sec), .tick_fast(tick_fast), .batt_ok(batt_ok),
    .live_time(live_time), .load_time(load_time), .load_stb(load_stb),
    .osc_stop(osc_stop));

  function automatic logic [7:0] fmask(int i);
    logic [7:0] m [8] = '{8'h3F, 8'h7F, 8'h7F, 8'h3F, 8'h07, 8'h3F, 8'h1F, 8'hFF};
    return m[i];
  endfunction

  function automatic logic [7:0] exp_rd(int i);
    logic [7:0] v = ub[i];
    if (i == 4) v[7] = batt_ok;
    if (i == 1 && ub[4][6] && !ub[1][7]) v[0] = tgl_m;
    return v;
  endfunction

  function automatic logic [AW-1:0] ca(int i);
    return {{(AW-3){1'b1}}, 3'(i)};
  endfunction

  task automatic chk(input string r, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic idle();
    ce_n = 1; oe_n = 1; we_n = 1;
  endtask

  task automatic wr_a(input logic [AW-1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; data_in = v; ce_n = 0; we_n = 0; oe_n = 1;
    @(negedge clk); idle(); ld_seen = load_stb; ld_val = load_time;
  endtask

  task automatic wr(input int i, input logic [7:0] v);
    wr_a(ca(i), v);
    ub[i] = (i == 4) ? (v & 8'h7F) : v;
  endtask

  task automatic rd_a(input logic [AW-1:0] a, output logic [7:0] v, output logic oe);
    @(negedge clk); addr = a; ce_n = 0; oe_n = 0; we_n = 1;
    @(negedge clk); v = data_out; oe = data_oe; idle();
  endtask

  task automatic rd_chk(input string r, input int i);
    logic [7:0] v; logic oe;
    rd_a(ca(i), v, oe);
    chk(r, {55'd0, oe, v}, {55'd0, 1'b1, exp_rd(i)});
  endtask

  task automatic model_copy();
    for (int i = 0; i < 8; i++) ub[i] = (ub[i] & ~fmask(i)) | (lv[i] & fmask(i));
  endtask

  task automatic pulse_sec();
    @(negedge clk); tick_sec = 1;
    @(negedge clk); tick_sec = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v; logic oe;
    for (int i = 0; i < 8; i++) begin lv[i] = 8'h00; ub[i] = 8'h00; end
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    // reset state
    chk("R2 reset oe", {63'd0, data_oe}, 64'd0);
    chk("R8 reset stb", {63'd0, load_stb}, 64'd0);
    chk("R9 reset osc", {63'd0, osc_stop}, 64'd0);
    rd_chk("R1 reset ctrl", 0);

    // R3 R4 R9: exhaustive byte sweep
    for (int i = 0; i < 8; i++)
      for (int k = 0; k < 256; k++) begin
        batt_ok = k[3];
        wr(i, 8'(k));
        if (i == 1) chk("R9 osc_stop", {63'd0, osc_stop}, {63'd0, k[7]});
        rd_chk(i == 4 ? "R4 batt" : "R3 rdback", i);
      end
    batt_ok = 1;
    wr(0, 8'h00);
    for (int i = 1; i < 8; i++) wr(i, 8'h00);

    // R1: nothing below the clock area responds
    for (int a = 0; a < 24; a++) begin
      wr_a(AW'(a), 8'hFF);
      rd_a(AW'(a), v, oe);
      chk("R1 outside oe", {63'd0, oe}, 64'd0);
      rd_chk("R1 outside no write", a % 8);
    end

    // R2: write with oe_n low wins, bus stays released
    @(negedge clk); addr = ca(7); data_in = 8'h5A; ce_n = 0; we_n = 0; oe_n = 0;
    @(negedge clk); chk("R2 write prio oe", {63'd0, data_oe}, 64'd0); idle(); ub[7] = 8'h5A;
    rd_chk("R2 write prio data", 7);
    @(negedge clk); chk("R2 idle release", {63'd0, data_oe}, 64'd0);

    // R5: tick copies fields only
    wr(3, 8'hC0);
    lv = '{8'hE1, 8'hD9, 8'hBB, 8'hFF, 8'hF7, 8'h31, 8'h12, 8'h99};
    pulse_sec(); model_copy();
    for (int i = 0; i < 8; i++) rd_chk("R5 copy", i);

    // R6: copy waits for held read
    lv = '{8'h02, 8'h11, 8'h22, 8'h13, 8'h03, 8'h14, 8'h05, 8'h26};
    @(negedge clk); addr = ca(2); ce_n = 0; oe_n = 0; we_n = 1; tick_sec = 1;
    @(negedge clk); tick_sec = 0; chk("R6 held read", {56'd0, data_out}, {56'd0, exp_rd(2)});
    @(negedge clk); chk("R6 held read", {56'd0, data_out}, {56'd0, exp_rd(2)});
    @(negedge clk); chk("R6 held read", {56'd0, data_out}, {56'd0, exp_rd(2)}); idle();
    model_copy();
    rd_chk("R6 after access", 2);
    rd_chk("R6 after access", 0);

    // R7: read halt
    wr(0, 8'h40);
    lv = '{8'h03, 8'h33, 8'h44, 8'h15, 8'h06, 8'h27, 8'h08, 8'h27};
    pulse_sec();
    rd_chk("R7 frozen", 2);
    wr(0, 8'h00); model_copy();
    rd_chk("R7 released", 2);
    rd_chk("R7 released", 0);

    // R8: write halt and load
    wr(0, 8'h80); wr(1, 8'h12); wr(2, 8'h34); wr(3, 8'hD6);
    lv = '{8'h01, 8'h55, 8'h56, 8'h17, 8'h02, 8'h09, 8'h10, 8'h30};
    pulse_sec();
    rd_chk("R8 frozen", 2);
    wr(0, 8'h07);
    chk("R8 stb", {63'd0, ld_seen}, 64'd1);
    begin
      logic [63:0] e;
      for (int i = 0; i < 8; i++) e[8*i +: 8] = ub[i] & fmask(i);
      chk("R8 load_time", ld_val, e);
    end
    @(negedge clk); chk("R8 stb single", {63'd0, load_stb}, 64'd0);
    repeat (3) @(negedge clk);
    rd_chk("R8 pending dropped", 2);
    rd_chk("R8 pending dropped", 3);

    // R10: frequency test toggle
    wr(4, 8'h40); wr(1, 8'h00);
    repeat (3) begin
      @(negedge clk); tick_fast = 1;
      @(negedge clk); tick_fast = 0; tgl_m = !tgl_m;
    end
    rd_chk("R10 toggle", 1);
    wr(1, 8'h80);
    @(negedge clk); tick_fast = 1;
    @(negedge clk); tick_fast = 0;
    rd_chk("R10 osc stopped", 1);
    wr(1, 8'h00);
    rd_chk("R10 held", 1);
    wr(4, 8'h00); wr(1, 8'h00);
    rd_chk("R10 test off", 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule